// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block keeps the tap count of an input delay line and publishes it to the analog delay elements, which lie outside the block. A tap count is an unsigned value from 0 to 511. A delay mode is fixed at build time. The count can be held at its reset value, loaded from a parallel input, or stepped one tap at a time. An update policy, also fixed at build time, decides when a requested value becomes the active one: at once, on the next transition of the sampled data line, or through a two-step commit driven by software. Because of the last two policies, a staged value is held apart from the active value until it is committed.

An optional second stage can be chained after the first to lengthen the delay. It has its own load, enable, direction and count inputs. It always follows the update policy of the first stage. Reset polarity is set by a parameter. A ready flag rises one cycle after reset is released. Every pin is a plain control or status pin: no data stream crosses the block, so no valid/ready handshake or back-pressure applies.

Top module: `tap_delay_ctrl`

## Requirements
- R1: While reset is active, `tap_out` equals `INIT_TAP`, `tap_out_ext` equals `INIT_TAP_EXT` (or 0 when the chain is off) and `ready` is 0. `ready` is 1 after the first clock edge at which reset is inactive.
- R2: With `RST_INVERT` = 0, reset is active when `rst_in` is 1. With `RST_INVERT` = 1, reset is active when `rst_in` is 0.
- R3: In mode FIXED, `tap_out` never leaves `INIT_TAP`, whatever `load`, `ce`, `inc` and `cnt_in` do.
- R4: In mode VAR_LOAD with the immediate policy, `load` high at a clock edge makes `tap_out` equal to `cnt_in` after that edge.
- R5: In mode VARIABLE, `ce` high at an edge moves the count by one tap: up when `inc` is 1, down when `inc` is 0.
- R6: Stepping saturates. An increment at 511 stays at 511, and a decrement at 0 stays at 0.
- R7: Under the edge-synchronous policy, a requested value is staged and `tap_out` keeps its value until an edge at which `data_in` differs from its value at the previous edge. The staged value becomes active at that edge. A transition with nothing staged changes nothing.
- R8: Under the manual policy, `load` with `ce` low stages `cnt_in`. `tap_out` changes only at an edge with `load` and `ce` both high while a value is staged. `load` and `ce` together with nothing staged change nothing.
- R9: Reset clears any staged value. After release, a data transition or a manual commit leaves `tap_out` at `INIT_TAP`.
- R10: With `CASCADE_EN` = 1, the extension stage follows its own `load_ext`, `ce_ext`, `inc_ext` and `cnt_in_ext` under the same policy, independently of the first stage. With `CASCADE_EN` = 0, `tap_out_ext` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Synchronous reset, polarity per `RST_INVERT` |
| load | input | 1 | Load / commit strobe, first stage |
| ce | input | 1 | Count enable, first stage |
| inc | input | 1 | Step direction, 1 = up, first stage |
| cnt_in | input | TAP_W | Parallel tap request, first stage |
| data_in | input | 1 | Sampled data line used for edge-synchronous commits |
| load_ext | input | 1 | Load / commit strobe, extension stage |
| ce_ext | input | 1 | Count enable, extension stage |
| inc_ext | input | 1 | Step direction, extension stage |
| cnt_in_ext | input | TAP_W | Parallel tap request, extension stage |
| tap_out | output | TAP_W | Active tap count, first stage |
| tap_out_ext | output | TAP_W | Active tap count, extension stage |
| ready | output | 1 | High from one cycle after reset release |

## Verification
The properties assume that `data_in` and the control strobes are synchronous to `clk` and that the reset line is driven to a known level from time zero. The bench meets this by changing every input only on the falling clock edge and by holding reset active from the start. The manual-commit and edge-hold properties also rely on `load`, `ce` and `data_in` being meaningful only after `ready` rises. The bench therefore applies requests only after a full reset sequence has completed.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {DM_FIXED, DM_VAR_LOAD, DM_VARIABLE} dly_mode_e;
  typedef enum logic [1:0] {UP_ASYNC, UP_SYNC, UP_MANUAL} upd_pol_e;
endpackage

// File: rtl/tdc_edge_det.sv
module tdc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_seen
);
  logic din_q;

  // During reset, track the line so that release shows no false transition.
  always_ff @(posedge clk) begin
    din_q <= din;
  end

  assign edge_seen = !rst && (din != din_q);
endmodule

// File: rtl/tdc_stage.sv
module tdc_stage import tdc_pkg::*; #(
  parameter int unsigned TAP_W  = 9,
  parameter dly_mode_e   MODE   = DM_VAR_LOAD,
  parameter upd_pol_e    POLICY = UP_ASYNC,
  parameter int unsigned INIT   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             ce,
  input  logic             inc,
  input  logic [TAP_W-1:0] cnt_in,
  input  logic             data_edge,
  output logic [TAP_W-1:0] tap
);
  localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] TAP_INIT = TAP_W'(INIT);
  localparam bit               MANUAL   = (POLICY == UP_MANUAL);

  logic [TAP_W-1:0] active_q, pend_q, base, req_val, staged;
  logic             pend_vld_q, req_vld;
  logic [TAP_W-1:0] active_d, pend_d;
  logic             pend_vld_d;

  always_comb begin
    base    = (POLICY != UP_ASYNC && pend_vld_q) ? pend_q : active_q;
    req_vld = 1'b0;
    req_val = base;
    case (MODE)
      DM_VAR_LOAD: begin
        req_vld = MANUAL ? (load && !ce) : load;
        req_val = cnt_in;
      end
      DM_VARIABLE: begin
        req_vld = MANUAL ? (ce && !load) : ce;
        if (inc) req_val = (base == TAP_MAX) ? TAP_MAX : base + 1'b1;
        else     req_val = (base == '0) ? '0 : base - 1'b1;
      end
      default: begin
        req_vld = 1'b0;
      end
    endcase
  end

  always_comb begin
    active_d   = active_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    staged     = req_vld ? req_val : pend_q;
    case (POLICY)
      UP_ASYNC: begin
        if (req_vld) active_d = req_val;
      end
      UP_SYNC: begin
        if (req_vld) begin
          pend_d     = req_val;
          pend_vld_d = 1'b1;
        end
        if (data_edge && (req_vld || pend_vld_q)) begin
          active_d   = staged;
          pend_vld_d = 1'b0;
        end
      end
      default: begin
        if (req_vld) begin
          pend_d     = req_val;
          pend_vld_d = 1'b1;
        end
        if (load && ce && pend_vld_q) begin
          active_d   = pend_q;
          pend_vld_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= TAP_INIT;
      pend_q     <= TAP_INIT;
      pend_vld_q <= 1'b0;
    end else begin
      active_q   <= active_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  assign tap = active_q;
endmodule

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl import tdc_pkg::*; #(
  parameter int unsigned TAP_W        = 9,
  parameter dly_mode_e   DELAY_MODE   = DM_VAR_LOAD,
  parameter dly_mode_e   DELAY_MODE_EXT = DM_VAR_LOAD,
  parameter upd_pol_e    UPDATE_POL   = UP_ASYNC,
  parameter int unsigned INIT_TAP     = 0,
  parameter int unsigned INIT_TAP_EXT = 0,
  parameter bit          CASCADE_EN   = 1'b0,
  parameter bit          RST_INVERT   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_in,
  input  logic             load,
  input  logic             ce,
  input  logic             inc,
  input  logic [TAP_W-1:0] cnt_in,
  input  logic             data_in,
  input  logic             load_ext,
  input  logic             ce_ext,
  input  logic             inc_ext,
  input  logic [TAP_W-1:0] cnt_in_ext,
  output logic [TAP_W-1:0] tap_out,
  output logic [TAP_W-1:0] tap_out_ext,
  output logic             ready
);
  logic rst_act, data_edge;

  assign rst_act = rst_in ^ RST_INVERT;

  always_ff @(posedge clk) begin
    if (rst_act) ready <= 1'b0;
    else         ready <= 1'b1;
  end

  tdc_edge_det u_edge (
    .clk(clk), .rst(rst_act), .din(data_in), .edge_seen(data_edge)
  );

  tdc_stage #(
    .TAP_W(TAP_W), .MODE(DELAY_MODE), .POLICY(UPDATE_POL), .INIT(INIT_TAP)
  ) u_main (
    .clk(clk), .rst(rst_act), .load(load), .ce(ce), .inc(inc),
    .cnt_in(cnt_in), .data_edge(data_edge), .tap(tap_out)
  );

  generate
    if (CASCADE_EN) begin : g_ext
      tdc_stage #(
        .TAP_W(TAP_W), .MODE(DELAY_MODE_EXT), .POLICY(UPDATE_POL),
        .INIT(INIT_TAP_EXT)
      ) u_ext (
        .clk(clk), .rst(rst_act), .load(load_ext), .ce(ce_ext),
        .inc(inc_ext), .cnt_in(cnt_in_ext), .data_edge(data_edge),
        .tap(tap_out_ext)
      );
    end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext  = ^{load_ext, ce_ext, inc_ext, cnt_in_ext};
      assign tap_out_ext = '0;
    end
  endgenerate
endmodule

// File: rtl/tap_delay_ctrl_chk.sv
module tap_delay_ctrl_chk import tdc_pkg::*; #(
  parameter int unsigned TAP_W        = 9,
  parameter dly_mode_e   DELAY_MODE   = DM_VAR_LOAD,
  parameter upd_pol_e    UPDATE_POL   = UP_ASYNC,
  parameter int unsigned INIT_TAP     = 0,
  parameter bit          CASCADE_EN   = 1'b0,
  parameter bit          RST_INVERT   = 1'b0
) (
  input logic             clk,
  input logic             rst_in,
  input logic             load,
  input logic             ce,
  input logic [TAP_W-1:0] cnt_in,
  input logic             data_in,
  input logic [TAP_W-1:0] tap_out,
  input logic [TAP_W-1:0] tap_out_ext,
  input logic             ready
);
  logic             rst_c, din_c;
  logic [TAP_W:0]   tap_w;

  assign rst_c = rst_in ^ RST_INVERT;
  assign tap_w = {1'b0, tap_out};

  always_ff @(posedge clk) din_c <= data_in;

  // R1: reset forces the initial tap and drops ready
  a_r1_reset_state: assert property (@(posedge clk)
    rst_c |=> (!ready && tap_out == TAP_W'(INIT_TAP)));

  generate
    if (DELAY_MODE == DM_FIXED) begin : g_fixed
      // R3: fixed mode holds its tap
      a_r3_fixed_hold: assert property (@(posedge clk) disable iff (rst_c)
        ready |-> tap_out == TAP_W'(INIT_TAP));
    end
    if (DELAY_MODE == DM_VARIABLE && UPDATE_POL == UP_ASYNC) begin : g_step
      // R5 / R6: moves by at most one tap and never wraps
      a_r5_single_step: assert property (@(posedge clk) disable iff (rst_c)
        ready |=> (tap_w == $past(tap_w) || tap_w == $past(tap_w) + 1'b1 ||
                   tap_w + 1'b1 == $past(tap_w)));
    end
    if (DELAY_MODE == DM_VAR_LOAD && UPDATE_POL == UP_ASYNC) begin : g_load
      // R4: immediate load
      a_r4_load_now: assert property (@(posedge clk) disable iff (rst_c)
        (ready && load) |=> tap_out == $past(cnt_in));
    end
    if (UPDATE_POL == UP_SYNC) begin : g_sync
      // R7: no data transition, no change
      a_r7_hold_without_edge: assert property (@(posedge clk) disable iff (rst_c)
        (ready && data_in == din_c) |=> $stable(tap_out));
    end
    if (UPDATE_POL == UP_MANUAL) begin : g_man
      // R8: only a load with enable can commit
      a_r8_commit_only: assert property (@(posedge clk) disable iff (rst_c)
        (ready && !(load && ce)) |=> $stable(tap_out));
    end
    if (!CASCADE_EN) begin : g_noext
      // R10: chain disabled keeps the extension at zero
      a_r10_ext_zero: assert property (@(posedge clk) tap_out_ext == '0);
    end
  endgenerate
endmodule

bind tap_delay_ctrl tap_delay_ctrl_chk #(
  .TAP_W(TAP_W), .DELAY_MODE(DELAY_MODE), .UPDATE_POL(UPDATE_POL),
  .INIT_TAP(INIT_TAP), .CASCADE_EN(CASCADE_EN), .RST_INVERT(RST_INVERT)
) u_chk (
  .clk(clk), .rst_in(rst_in), .load(load), .ce(ce), .cnt_in(cnt_in),
  .data_in(data_in), .tap_out(tap_out), .tap_out_ext(tap_out_ext),
  .ready(ready)
);

// File: tb/sim_tap_delay_ctrl.sv
`timescale 1ns/1ps
module sim_tap_delay_ctrl;
  import tdc_pkg::*;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 0, ce = 0, inc = 0, din = 0;
  logic load_x = 0, ce_x = 0, inc_x = 0;
  logic [W-1:0] cnt = '0, cnt_x = '0;
  logic [W-1:0] t0, e0, t1, e1, t2, e2, t3, e3, t4, e4;
  logic r0, r1, r2, r3, r4;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  // Main: loadable, immediate, chained
  tap_delay_ctrl #(.DELAY_MODE(DM_VAR_LOAD), .DELAY_MODE_EXT(DM_VAR_LOAD),
    .UPDATE_POL(UP_ASYNC), .INIT_TAP(5), .INIT_TAP_EXT(7), .CASCADE_EN(1'b1))
  u0 (.clk(clk), .rst_in(rst), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt),
      .data_in(din), .load_ext(load_x), .ce_ext(ce_x), .inc_ext(inc_x),
      .cnt_in_ext(cnt_x), .tap_out(t0), .tap_out_ext(e0), .ready(r0));
  // Stepping, immediate, no chain
  tap_delay_ctrl #(.DELAY_MODE(DM_VARIABLE), .UPDATE_POL(UP_ASYNC), .INIT_TAP(2))
  u1 (.clk(clk), .rst_in(rst), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt),
      .data_in(din), .load_ext(load_x), .ce_ext(ce_x), .inc_ext(inc_x),
      .cnt_in_ext(cnt_x), .tap_out(t1), .tap_out_ext(e1), .ready(r1));
  // Loadable, edge-synchronous, active-low reset
  tap_delay_ctrl #(.DELAY_MODE(DM_VAR_LOAD), .UPDATE_POL(UP_SYNC), .INIT_TAP(10),
    .RST_INVERT(1'b1))
  u2 (.clk(clk), .rst_in(~rst), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt),
      .data_in(din), .load_ext(load_x), .ce_ext(ce_x), .inc_ext(inc_x),
      .cnt_in_ext(cnt_x), .tap_out(t2), .tap_out_ext(e2), .ready(r2));
  // Loadable, manual commit
  tap_delay_ctrl #(.DELAY_MODE(DM_VAR_LOAD), .UPDATE_POL(UP_MANUAL), .INIT_TAP(20))
  u3 (.clk(clk), .rst_in(rst), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt),
      .data_in(din), .load_ext(load_x), .ce_ext(ce_x), .inc_ext(inc_x),
      .cnt_in_ext(cnt_x), .tap_out(t3), .tap_out_ext(e3), .ready(r3));
  // Fixed
  tap_delay_ctrl #(.DELAY_MODE(DM_FIXED), .UPDATE_POL(UP_ASYNC), .INIT_TAP(33))
  u4 (.clk(clk), .rst_in(rst), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt),
      .data_in(din), .load_ext(load_x), .ce_ext(ce_x), .inc_ext(inc_x),
      .cnt_in_ext(cnt_x), .tap_out(t4), .tap_out_ext(e4), .ready(r4));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic idle();
    load = 0; ce = 0; inc = 0; load_x = 0; ce_x = 0; inc_x = 0;
  endtask

  task automatic do_reset();
    idle(); rst = 1; step(2); rst = 0; step(1);
  endtask

  task automatic t_reset();
    idle(); rst = 1; step(2);
    chk("R1 tap in reset", t0, 5);
    chk("R1 ext in reset", e0, 7);
    chk("R1 ready in reset", r0, 0);
    chk("R2 active-low reset tap", t2, 10);
    chk("R2 active-low ready", r2, 0);
    rst = 0; step(1);
    chk("R1 ready after release", r0, 1);
    chk("R2 ready after release", r2, 1);
  endtask

  task automatic t_fixed();
    do_reset();
    load = 1; cnt = 100; ce = 1; inc = 1; step(3); idle();
    chk("R3 fixed holds", t4, 33);
  endtask

  task automatic t_load();
    do_reset();
    load = 1; cnt = 300; step(1); load = 0;
    chk("R4 load 300", t0, 300);
    load = 1; cnt = 0; step(1); load = 0;
    chk("R4 load 0", t0, 0);
  endtask

  task automatic t_step();
    do_reset();
    ce = 1; inc = 0; step(1);
    chk("R5 decrement", t1, 1);
    step(2);
    chk("R6 floor at 0", t1, 0);
    inc = 1; step(3);
    chk("R5 increment", t1, 3);
    step(520);
    chk("R6 ceiling at 511", t1, 511);
    idle();
  endtask

  task automatic t_sync();
    do_reset();
    load = 1; cnt = 77; step(1); load = 0;
    chk("R7 staged not active", t2, 10);
    step(2);
    chk("R7 still held", t2, 10);
    din = ~din; step(1);
    chk("R7 commit on edge", t2, 77);
    din = ~din; step(1);
    chk("R7 edge without staged", t2, 77);
    load = 1; cnt = 99; step(1); idle();
    do_reset();
    din = ~din; step(1);
    chk("R9 reset clears staged (sync)", t2, 10);
  endtask

  task automatic t_manual();
    do_reset();
    load = 1; ce = 1; step(1); idle();
    chk("R8 commit with nothing staged", t3, 20);
    load = 1; cnt = 150; step(1); idle();
    chk("R8 first load only stages", t3, 20);
    ce = 1; step(1); idle();
    chk("R8 enable alone no commit", t3, 20);
    load = 1; ce = 1; step(1); idle();
    chk("R8 second load commits", t3, 150);
    load = 1; cnt = 200; step(1); idle();
    do_reset();
    load = 1; ce = 1; step(1); idle();
    chk("R9 reset clears staged (manual)", t3, 20);
  endtask

  task automatic t_cascade();
    do_reset();
    load_x = 1; cnt_x = 400; step(1); idle();
    chk("R10 ext loads", e0, 400);
    chk("R10 main untouched", t0, 5);
    chk("R10 chain off stays zero", e1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_load();
    t_step();
    t_sync();
    t_manual();
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule